// File: doc/BRIEF.md
# Processor Status Register Unit

This block keeps the eight condition and control bits of a small 8-bit processor in one register. The arithmetic unit updates the five arithmetic flags (half carry, overflow, negative, zero, carry) through a per-flag enable, so an instruction changes only the flags it defines. Software can read and write the whole register at its I/O address. The sign flag is not stored. It is always formed as negative xor overflow.

The global interrupt enable bit is cleared by hardware when an interrupt is taken and set again by a return from interrupt. The unit also presents this bit to the interrupt controller as the permission to raise any interrupt. A single transfer bit supports two bit-copy operations: bit-store copies one selected bit of an 8-bit register operand into the transfer bit, and bit-load returns the operand with the selected bit replaced by the transfer bit.

Top module: `cpu_status_unit`

## Requirements
- R1: After reset every bit of `status_q` is 0 and `irq_allowed` is 0.
- R2: The register layout is I=bit 7, T=bit 6, H=bit 5, S=bit 4, V=bit 3, N=bit 2, Z=bit 1, C=bit 0. A write with `io_wr`=1 at `io_addr`=0x3F loads the register on the next clock. A read at 0x3F returns `status_q`, and a read at any other address returns 0.
- R3: Bit 4 of `status_q` always equals bit 2 xor bit 3. A value written to bit 4 has no effect.
- R4: `alu_flag_val` and `alu_flag_we` are ordered {H,V,N,Z,C} (bit 4 down to bit 0). A flag whose enable is 1 takes the new value on the next clock, and a flag whose enable is 0 keeps its value.
- R5: When a direct write and any hardware update (arithmetic flags, interrupt taken or return, bit-store) occur in the same cycle, the direct write wins for every bit.
- R6: `irq_taken` clears I on the next clock. If `irq_return` is asserted in the same cycle, the clear still wins.
- R7: `irq_return` alone sets I on the next clock.
- R8: With `bst_en`=1, T takes bit `bit_sel` of `bit_operand` on the next clock.
- R9: `bld_result` equals `bit_operand` with bit `bit_sel` replaced by the current T. This output is combinational.
- R10: `irq_allowed` always equals I. When it is 0, no interrupt is permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 6 | I/O address for reads and writes |
| io_wr | input | 1 | Write strobe for the I/O bus |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; 0 unless the address hits |
| alu_flag_we | input | 5 | Per-flag update enables {H,V,N,Z,C} |
| alu_flag_val | input | 5 | New flag values {H,V,N,Z,C} |
| irq_taken | input | 1 | An interrupt is being entered |
| irq_return | input | 1 | Return from interrupt |
| bst_en | input | 1 | Bit-store into T |
| bit_sel | input | 3 | Selected bit position |
| bit_operand | input | 8 | Register operand for bit copy |
| bld_result | output | 8 | Operand with the selected bit set to T |
| status_q | output | 8 | Current register contents |
| irq_allowed | output | 1 | Global interrupt permission |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a direct write arriving together with a full set of arithmetic flag updates. The other is an interrupt entry coinciding with a return. In normal instruction flow neither pair occurs together, so the bench drives both sources in one cycle on purpose and checks which one lands. The forced sign bit is reached by writing patterns whose bit 4 disagrees with N xor V.

// File: rtl/cpu_status_pkg.sv
`timescale 1ns/1ps
package cpu_status_pkg;
   localparam int unsigned SR_W      = 8;
   localparam int unsigned POS_I     = 7;
   localparam int unsigned POS_T     = 6;
   localparam int unsigned POS_H     = 5;
   localparam int unsigned POS_S     = 4;
   localparam int unsigned POS_V     = 3;
   localparam int unsigned POS_N     = 2;
   localparam int unsigned POS_Z     = 1;
   localparam int unsigned POS_C     = 0;
   localparam int unsigned NUM_AFLAG = 5;
   typedef logic [NUM_AFLAG-1:0] aflag_t;   // {H,V,N,Z,C}

   function automatic logic [SR_W-1:0] sr_pack(input logic i, input logic t,
                                                input aflag_t f);
      logic [SR_W-1:0] r;
      r        = '0;
      r[POS_I] = i;
      r[POS_T] = t;
      r[POS_H] = f[4];
      r[POS_V] = f[3];
      r[POS_N] = f[2];
      r[POS_Z] = f[1];
      r[POS_C] = f[0];
      r[POS_S] = f[3] ^ f[2];
      return r;
   endfunction
endpackage

// File: rtl/sr_flag_merge.sv
`timescale 1ns/1ps
module sr_flag_merge #(
   parameter int unsigned NF = 5
) (
   input  logic [NF-1:0] cur,
   input  logic [NF-1:0] we,
   input  logic [NF-1:0] val,
   output logic [NF-1:0] nxt
);
   for (genvar g = 0; g < NF; g++) begin : g_bit
      assign nxt[g] = we[g] ? val[g] : cur[g];
   end
endmodule

// File: rtl/sr_bit_copy.sv
`timescale 1ns/1ps
module sr_bit_copy #(
   parameter int unsigned OPND_W = 8,
   localparam int unsigned SEL_W = $clog2(OPND_W)
) (
   input  logic [OPND_W-1:0] operand,
   input  logic [SEL_W-1:0]  sel,
   input  logic              t_bit,
   output logic              picked,
   output logic [OPND_W-1:0] inserted
);
   logic [OPND_W-1:0] hit;
   for (genvar g = 0; g < OPND_W; g++) begin : g_pos
      assign hit[g]      = (sel == SEL_W'(g));
      assign inserted[g] = hit[g] ? t_bit : operand[g];
   end
   assign picked = |(hit & operand);
endmodule

// File: rtl/sr_ie_ctrl.sv
`timescale 1ns/1ps
module sr_ie_ctrl (
   input  logic cur,
   input  logic wr_hit,
   input  logic wr_val,
   input  logic taken,
   input  logic ret,
   output logic nxt
);
   always_comb begin
      if (wr_hit)     nxt = wr_val;
      else if (taken) nxt = 1'b0;
      else if (ret)   nxt = 1'b1;
      else            nxt = cur;
   end
endmodule

// File: rtl/cpu_status_unit.sv
`timescale 1ns/1ps
module cpu_status_unit
   import cpu_status_pkg::*;
#(
   parameter int unsigned ADDR_W     = 6,
   parameter logic [ADDR_W-1:0] SR_IO_ADDR = 6'h3F,
   parameter int unsigned OPND_W     = 8,
   localparam int unsigned SEL_W     = $clog2(OPND_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic [SR_W-1:0]   io_wdata,
   output logic [SR_W-1:0]   io_rdata,
   input  logic [NUM_AFLAG-1:0] alu_flag_we,
   input  logic [NUM_AFLAG-1:0] alu_flag_val,
   input  logic              irq_taken,
   input  logic              irq_return,
   input  logic              bst_en,
   input  logic [SEL_W-1:0]  bit_sel,
   input  logic [OPND_W-1:0] bit_operand,
   output logic [OPND_W-1:0] bld_result,
   output logic [SR_W-1:0]   status_q,
   output logic              irq_allowed
);
   if (OPND_W < 2 || (OPND_W & (OPND_W - 1)) != 0) begin : g_bad_opnd
      $error("OPND_W must be a power of two of at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end

   aflag_t flag_q, flag_merged, flag_d;
   logic   i_q, i_d, t_q, t_d, picked;
   logic   addr_hit, wr_hit;

   assign addr_hit = (io_addr == SR_IO_ADDR);
   assign wr_hit   = io_wr && addr_hit;

   sr_flag_merge #(.NF(NUM_AFLAG)) u_merge (
      .cur(flag_q), .we(alu_flag_we), .val(alu_flag_val), .nxt(flag_merged));

   sr_bit_copy #(.OPND_W(OPND_W)) u_copy (
      .operand(bit_operand), .sel(bit_sel), .t_bit(t_q),
      .picked(picked), .inserted(bld_result));

   sr_ie_ctrl u_ie (
      .cur(i_q), .wr_hit(wr_hit), .wr_val(io_wdata[POS_I]),
      .taken(irq_taken), .ret(irq_return), .nxt(i_d));

   always_comb begin
      if (wr_hit) begin
         flag_d = {io_wdata[POS_H], io_wdata[POS_V], io_wdata[POS_N],
                   io_wdata[POS_Z], io_wdata[POS_C]};
         t_d    = io_wdata[POS_T];
      end else begin
         flag_d = flag_merged;
         t_d    = bst_en ? picked : t_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         t_q    <= 1'b0;
         i_q    <= 1'b0;
      end else begin
         flag_q <= flag_d;
         t_q    <= t_d;
         i_q    <= i_d;
      end
   end

   assign status_q    = sr_pack(i_q, t_q, flag_q);
   assign io_rdata    = addr_hit ? status_q : '0;
   assign irq_allowed = i_q;
endmodule

// File: rtl/cpu_status_chk.sv
`timescale 1ns/1ps
module cpu_status_chk #(
   parameter int unsigned ADDR_W     = 6,
   parameter logic [ADDR_W-1:0] SR_IO_ADDR = 6'h3F,
   parameter int unsigned OPND_W     = 8,
   localparam int unsigned SEL_W     = $clog2(OPND_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic [7:0]        io_wdata,
   input logic [7:0]        io_rdata,
   input logic [4:0]        alu_flag_we,
   input logic [4:0]        alu_flag_val,
   input logic              irq_taken,
   input logic              irq_return,
   input logic              bst_en,
   input logic [SEL_W-1:0]  bit_sel,
   input logic [OPND_W-1:0] bit_operand,
   input logic [OPND_W-1:0] bld_result,
   input logic [7:0]        status_q,
   input logic              irq_allowed
);
   logic hit;
   assign hit = io_wr && (io_addr == SR_IO_ADDR);

   AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[4] == (status_q[3] ^ status_q[2]));                         // R3
   AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> status_q == {$past(io_wdata[7:5]), $past(io_wdata[3] ^ io_wdata[2]),
                           $past(io_wdata[3:0])});                          // R5
   AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !alu_flag_we[0]) |=> $stable(status_q[0]));                 // R4
   AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !alu_flag_we[4]) |=> $stable(status_q[5]));                 // R4
   AST_TAKEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && irq_taken) |=> !status_q[7]);                               // R6
   AST_RETURN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !irq_taken && irq_return) |=> status_q[7]);                 // R7
   AST_BIT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && bst_en) |=> status_q[6] == $past(bit_operand[bit_sel]));    // R8
   AST_BIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      bld_result[bit_sel] == status_q[6]);                                 // R9
   AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_allowed == status_q[7]);                                         // R10
   AST_READ_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (io_addr != SR_IO_ADDR) |-> io_rdata == 8'h00);                      // R2
endmodule

bind cpu_status_unit cpu_status_chk #(
   .ADDR_W(ADDR_W), .SR_IO_ADDR(SR_IO_ADDR), .OPND_W(OPND_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
   .io_wdata(io_wdata), .io_rdata(io_rdata), .alu_flag_we(alu_flag_we),
   .alu_flag_val(alu_flag_val), .irq_taken(irq_taken), .irq_return(irq_return),
   .bst_en(bst_en), .bit_sel(bit_sel), .bit_operand(bit_operand),
   .bld_result(bld_result), .status_q(status_q), .irq_allowed(irq_allowed));

// File: tb/cpu_status_unit_bench.sv
`timescale 1ns/1ps
module cpu_status_unit_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] io_addr = '0;
   logic       io_wr = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata;
   logic [4:0] alu_flag_we = '0;
   logic [4:0] alu_flag_val = '0;
   logic       irq_taken = 1'b0;
   logic       irq_return = 1'b0;
   logic       bst_en = 1'b0;
   logic [2:0] bit_sel = '0;
   logic [7:0] bit_operand = '0;
   logic [7:0] bld_result;
   logic [7:0] status_q;
   logic       irq_allowed;
   int         n_run = 0;
   int         n_fail = 0;

   always #4 clk = ~clk;

   cpu_status_unit u_cpu_status_unit (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .alu_flag_we(alu_flag_we),
      .alu_flag_val(alu_flag_val), .irq_taken(irq_taken), .irq_return(irq_return),
      .bst_en(bst_en), .bit_sel(bit_sel), .bit_operand(bit_operand),
      .bld_result(bld_result), .status_q(status_q), .irq_allowed(irq_allowed));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic idle();
      io_wr = 0; alu_flag_we = '0; irq_taken = 0; irq_return = 0; bst_en = 0;
      io_addr = 6'h3F;
   endtask

   // drive at negedge, one clock, sample at next negedge
   task automatic step();
      @(posedge clk); @(negedge clk); idle();
   endtask

   task automatic wr_sr(input logic [7:0] v);
      io_addr = 6'h3F; io_wr = 1; io_wdata = v; step();
   endtask

   task automatic t_reset();
      check("R1 status", status_q, 8'h00);
      check("R1 irq_allowed", {7'd0, irq_allowed}, 8'h00);
   endtask

   task automatic t_direct();
      wr_sr(8'hFF);  check("R2 write FF", io_rdata, 8'hEF);
      wr_sr(8'h10);  check("R3 S written alone ignored", status_q, 8'h00);
      wr_sr(8'h04);  check("R3 S from N", status_q, 8'h14);
      io_addr = 6'h3E; #1;
      check("R2 other address reads 0", io_rdata, 8'h00);
      io_addr = 6'h3F; io_wr = 0; io_wdata = 8'hAA; io_addr = 6'h1F; io_wr = 1; step();
      check("R2 write elsewhere ignored", status_q, 8'h14);
   endtask

   task automatic t_alu();
      wr_sr(8'h00);
      alu_flag_we = 5'b11111; alu_flag_val = 5'b01010; step();
      check("R4 all flags", status_q, 8'h1A);
      alu_flag_we = 5'b00001; alu_flag_val = 5'b11111; step();
      check("R4 carry only", status_q, 8'h1B);
      alu_flag_we = 5'b10000; alu_flag_val = 5'b10000; step();
      check("R4 half only", status_q, 8'h3B);
   endtask

   task automatic t_collide();
      wr_sr(8'h80);
      io_wr = 1; io_wdata = 8'h41; alu_flag_we = 5'b11111; alu_flag_val = 5'b11110;
      irq_taken = 1; bst_en = 1; bit_operand = 8'h00; bit_sel = 3'd0; step();
      check("R5 write wins", status_q, 8'h41);
   endtask

   task automatic t_irq();
      wr_sr(8'h80);
      check("R10 allowed after set", {7'd0, irq_allowed}, 8'h01);
      irq_taken = 1; step();
      check("R6 taken clears", status_q, 8'h00);
      check("R10 allowed follows I", {7'd0, irq_allowed}, 8'h00);
      irq_return = 1; step();
      check("R7 return sets", status_q, 8'h80);
      irq_taken = 1; irq_return = 1; step();
      check("R6 taken beats return", status_q, 8'h00);
   endtask

   task automatic t_bitcopy();
      wr_sr(8'h00);
      bst_en = 1; bit_operand = 8'h20; bit_sel = 3'd5; step();
      check("R8 store one", status_q, 8'h40);
      bit_operand = 8'h00; bit_sel = 3'd3; #1;
      check("R9 load T=1", bld_result, 8'h08);
      bst_en = 1; bit_operand = 8'hEF; bit_sel = 3'd4; step();
      check("R8 store zero", status_q, 8'h00);
      bit_operand = 8'hFF; bit_sel = 3'd7; #1;
      check("R9 load T=0", bld_result, 8'h7F);
   endtask

   initial begin
      #800000;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_direct();
      t_alu();
      t_collide();
      t_irq();
      t_bitcopy();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule